// File: doc/BRIEF.md
# Strobe-Based Power Rail Sequencer

This block drives the enable lines of four output rails (negative LDO, negative charge pump, positive LDO, positive charge pump). In register mode each rail is tied to one of four strobe slots through a 2-bit field. The strobes fire one after another, separated by programmable delays counted in milliseconds. Power-up walks the strobes from the first to the fourth. Power-down walks them backwards, and each delay sits between the same pair of strobes as it does on the way up.

The block also has a pin mode. When no sequence is running and the wake input is high, a rising edge on a request pin turns its rail on and a falling edge turns it off. A wake input moves the block between SLEEP and the awake modes. Single-cycle command pulses start a register-ordered power-up or power-down. A fault input forces an orderly shutdown. The block takes a timebase tick, TICKS_PER_MS ticks per millisecond, so that the 5.5 ms start lead after wake can be expressed exactly.

Top module: `rail_strober`

## Requirements
- R1: After reset, and for as long as `wake` stays low, `mode` is SLEEP (encoding 2'b00), `rail_en` is 0 and `busy` is 0. The other mode encodings are STANDBY 2'b01 and ACTIVE 2'b10. Encoding 2'b11 never appears.
- R2: In SLEEP, if `wake` is seen high while every `req` bit is low, the block enters STANDBY on the next cycle with all rails off.
- R3: A `cmd_up` pulse while idle and awake starts a power-up. Strobe n (n = 0..3) enables every rail whose field `slot_map[2r+1:2r]` equals n. Rail index r is 0 for the negative LDO, 1 for the negative pump, 2 for the positive LDO and 3 for the positive pump. Strobe 0 fires after DLY0, and strobe n fires DLYn after strobe n-1. DLYn is `dly_cfg[4n+3:4n]` in ms, which is DLYn*TICKS_PER_MS ticks. The count starts on the cycle after the previous event, and a delay of 0 fires on the next cycle.
- R4: A strobe with no rail assigned to it still uses up its delay, so the timing of the later strobes does not change.
- R5: A power-down waits DLY0 and then clears the rails on slot 3. It then waits DLY3 and clears slot 2, waits DLY2 and clears slot 1, and waits DLY1 and clears slot 0. It ends in STANDBY if `wake` is high. No rail turns on during a power-down.
- R6: A `cmd_down` pulse while idle with any rail on starts a power-down. `cmd_down` takes priority over `cmd_up` in the same cycle. The commands act only in the cycle they are high.
- R7: A `fault` while idle with rails on, or at any point during a power-up, starts a power-down that ends in STANDBY.
- R8: While `busy` is high, edges on `req` have no effect, and no rail turns off during a power-up.
- R9: When idle and awake, a rising edge on `req[r]` enables rail r and a falling edge disables it, however the rail was enabled. With all rails off, `mode` reads STANDBY. With any rail on, it reads ACTIVE.
- R10: When `wake` goes low with rails on, the block runs a power-down, including one that interrupts a power-up, and then enters SLEEP. When `wake` goes low with no rails on, the block enters SLEEP on the next cycle.
- R11: In SLEEP, if `wake` is seen high while any `req` bit is high, the block runs a power-up. Its first strobe fires WAKE_LEAD_TICKS ticks later (default 11, which is 5.5 ms), in place of DLY0.
- R12: Rail 2 is never on while rail 0 is off. A request to enable rail 2 while rail 0 is off is dropped, and turning rail 0 off also turns rail 2 off.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wake | input | 1 | Wake level; low requests SLEEP |
| req | input | 4 | Per-rail request pins; bit r controls rail r |
| cmd_up | input | 1 | Single-cycle power-up command |
| cmd_down | input | 1 | Single-cycle power-down command |
| fault | input | 1 | Fault indication (undervoltage or overtemperature) |
| time_tick | input | 1 | Timebase tick, TICKS_PER_MS per millisecond |
| slot_map | input | 8 | Strobe slot per rail, 2 bits each |
| dly_cfg | input | 16 | DLY0..DLY3, 4 bits each, in ms |
| rail_en | output | 4 | Rail enables |
| busy | output | 1 | High while a sequence is running |
| mode | output | 2 | 00 SLEEP, 01 STANDBY, 10 ACTIVE |

## Verification
The sequencer is run with the default slot map and equal delays, and that run separates forward order from reverse order. A second map shares slots, leaves slots empty and uses zero and unequal delays, which exposes any timer that skips an empty slot or misreads a zero delay. A third map puts the positive LDO ahead of the negative LDO to test the interlock. The runs also cover these stimulus patterns:
- pin toggles during a power-up, against pin toggles when the block is idle, to separate ignored edges from applied ones;
- a fault, a combined up/down command, and wake dropping, to separate the paths that end in STANDBY from the one that ends in SLEEP;
- waking with a request pin high, to expose the longer start lead.

// File: rtl/rs_pkg.sv
package rs_pkg;
  typedef enum logic [1:0] {
    MODE_SLEEP   = 2'b00,
    MODE_STANDBY = 2'b01,
    MODE_ACTIVE  = 2'b10
  } pwr_mode_e;

  typedef enum logic [1:0] {
    PH_IDLE = 2'b00,
    PH_UP   = 2'b01,
    PH_DOWN = 2'b10
  } phase_e;

  localparam int RAILS     = 4;
  localparam int SLOT_W    = 2;
  localparam int RAIL_VNEG = 0;
  localparam int RAIL_VPOS = 2;
endpackage

// File: rtl/rs_edge.sv
module rs_edge #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] din,
  output logic [W-1:0] rise,
  output logic [W-1:0] fall
);
  logic [W-1:0] din_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) din_q <= '0;
    else        din_q <= din;
  end

  assign rise = din & ~din_q;
  assign fall = ~din & din_q;
endmodule

// File: rtl/rs_slot_decode.sv
module rs_slot_decode #(
  parameter int RAILS  = 4,
  parameter int SLOT_W = 2
) (
  input  logic [RAILS*SLOT_W-1:0] slot_map,
  input  logic [SLOT_W-1:0]       strobe,
  output logic [RAILS-1:0]        hit
);
  for (genvar r = 0; r < RAILS; r++) begin : g_rail
    assign hit[r] = (slot_map[r*SLOT_W +: SLOT_W] == strobe);
  end
endmodule

// File: rtl/rs_tick_timer.sv
module rs_tick_timer #(
  parameter int CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic             tick,
  input  logic [CNT_W-1:0] target,
  output logic             done
);
  logic [CNT_W-1:0] cnt;

  assign done = (cnt == target);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt <= '0;
    else if (clr)           cnt <= '0;
    else if (tick && !done) cnt <= cnt + 1'b1;
  end
endmodule

// File: rtl/rail_strober.sv
module rail_strober
  import rs_pkg::*;
#(
  parameter int TICKS_PER_MS    = 2,
  parameter int WAKE_LEAD_TICKS = 11,
  parameter int DLY_W           = 4
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    wake,
  input  logic [RAILS-1:0]        req,
  input  logic                    cmd_up,
  input  logic                    cmd_down,
  input  logic                    fault,
  input  logic                    time_tick,
  input  logic [RAILS*SLOT_W-1:0] slot_map,
  input  logic [4*DLY_W-1:0]      dly_cfg,
  output logic [RAILS-1:0]        rail_en,
  output logic                    busy,
  output logic [1:0]              mode
);
  localparam int NSTROBE = 1 << SLOT_W;
  localparam int DLY_MAX = ((1 << DLY_W) - 1) * TICKS_PER_MS;
  localparam int MAX_T   = (WAKE_LEAD_TICKS > DLY_MAX) ? WAKE_LEAD_TICKS : DLY_MAX;
  localparam int CNT_W   = $clog2(MAX_T + 1);

  phase_e            ph, ph_n;
  logic [SLOT_W-1:0] step, step_n;
  logic [RAILS-1:0]  en, en_n;
  logic              sleep_q, sleep_n;
  logic              to_sleep, to_sleep_n;
  logic              lead, lead_n;
  logic              clr, done;
  logic [RAILS-1:0]  rise, fall, hit;
  logic [SLOT_W-1:0] dsel, strobe;
  logic [CNT_W-1:0]  target;
  logic [DLY_W-1:0]  dly_a [NSTROBE];

  for (genvar k = 0; k < NSTROBE; k++) begin : g_dly
    assign dly_a[k] = dly_cfg[k*DLY_W +: DLY_W];
  end

  rs_edge #(.W(RAILS)) u_edge (
    .clk(clk), .rst_n(rst_n), .din(req), .rise(rise), .fall(fall)
  );

  // Power-down walks the slots backwards; delay index mirrors (0, 3, 2, 1).
  assign strobe = (ph == PH_DOWN) ? ~step : step;
  assign dsel   = (ph == PH_DOWN) ? (SLOT_W'(0) - step) : step;

  rs_slot_decode #(.RAILS(RAILS), .SLOT_W(SLOT_W)) u_dec (
    .slot_map(slot_map), .strobe(strobe), .hit(hit)
  );

  assign target = (ph == PH_UP && step == '0 && lead)
                ? CNT_W'(WAKE_LEAD_TICKS)
                : CNT_W'(dly_a[dsel]) * CNT_W'(TICKS_PER_MS);

  rs_tick_timer #(.CNT_W(CNT_W)) u_tmr (
    .clk(clk), .rst_n(rst_n), .clr(clr), .tick(time_tick),
    .target(target), .done(done)
  );

  always_comb begin
    ph_n       = ph;
    step_n     = step;
    en_n       = en;
    sleep_n    = sleep_q;
    to_sleep_n = to_sleep;
    lead_n     = lead;
    clr        = 1'b1;
    if (sleep_q) begin
      en_n = '0;
      if (wake) begin
        sleep_n = 1'b0;
        if (|req) begin
          ph_n = PH_UP; step_n = '0; lead_n = 1'b1;
        end
      end
    end else begin
      unique case (ph)
        PH_IDLE: begin
          if (!wake) begin
            if (|en) begin ph_n = PH_DOWN; step_n = '0; to_sleep_n = 1'b1; end
            else sleep_n = 1'b1;
          end else if (fault || cmd_down) begin
            if (|en) begin ph_n = PH_DOWN; step_n = '0; to_sleep_n = 1'b0; end
          end else if (cmd_up) begin
            ph_n = PH_UP; step_n = '0; lead_n = 1'b0;
          end else begin
            en_n = (en | rise) & ~fall;
          end
        end
        PH_UP: begin
          if (!wake) begin
            ph_n = PH_DOWN; step_n = '0; to_sleep_n = 1'b1;
          end else if (fault || cmd_down) begin
            ph_n = PH_DOWN; step_n = '0; to_sleep_n = 1'b0;
          end else if (done) begin
            en_n = en | hit;
            if (step == SLOT_W'(NSTROBE - 1)) ph_n = PH_IDLE;
            else step_n = step + 1'b1;
          end else begin
            clr = 1'b0;
          end
        end
        PH_DOWN: begin
          if (done) begin
            en_n = en & ~hit;
            if (step == SLOT_W'(NSTROBE - 1)) begin
              ph_n = PH_IDLE;
              if (to_sleep || !wake) sleep_n = 1'b1;
            end else begin
              step_n = step + 1'b1;
            end
          end else begin
            clr = 1'b0;
          end
        end
        default: ph_n = PH_IDLE;
      endcase
    end
    // Positive LDO may only run on top of the negative LDO.
    en_n[RAIL_VPOS] = en_n[RAIL_VPOS] & en_n[RAIL_VNEG];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph       <= PH_IDLE;
      step     <= '0;
      en       <= '0;
      sleep_q  <= 1'b1;
      to_sleep <= 1'b0;
      lead     <= 1'b0;
    end else begin
      ph       <= ph_n;
      step     <= step_n;
      en       <= en_n;
      sleep_q  <= sleep_n;
      to_sleep <= to_sleep_n;
      lead     <= lead_n;
    end
  end

  assign rail_en = en;
  assign busy    = (ph != PH_IDLE);
  assign mode    = sleep_q ? MODE_SLEEP : ((|en) ? MODE_ACTIVE : MODE_STANDBY);
endmodule

// File: rtl/rail_strober_chk.sv
module rail_strober_chk (
  input logic       clk,
  input logic       rst_n,
  input logic [3:0] rail_en,
  input logic       busy,
  input logic [1:0] mode,
  input logic [1:0] ph
);
  logic seen;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) seen <= 1'b0;
    else        seen <= 1'b1;
  end

  a_r12_vpos_needs_vneg: assert property (@(posedge clk) disable iff (!rst_n)
    rail_en[2] |-> rail_en[0]);

  a_r1_sleep_dark: assert property (@(posedge clk) disable iff (!rst_n)
    (mode == 2'b00) |-> (rail_en == 4'b0 && !busy));

  a_r1_mode_legal: assert property (@(posedge clk) disable iff (!rst_n)
    mode != 2'b11);

  a_r8_up_no_drop: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ph == 2'b01 && $past(ph) == 2'b01) |->
      ((rail_en & $past(rail_en)) == $past(rail_en)));

  a_r5_down_no_rise: assert property (@(posedge clk) disable iff (!rst_n)
    (seen && ph == 2'b10 && $past(ph) == 2'b10) |->
      ((rail_en & ~$past(rail_en)) == 4'b0));
endmodule

bind rail_strober rail_strober_chk u_chk (
  .clk(clk), .rst_n(rst_n), .rail_en(rail_en), .busy(busy),
  .mode(mode), .ph(ph)
);

// File: tb/rail_strober_test.sv
`timescale 1ns/1ps
module rail_strober_test;
  localparam int TPM = 2;
  localparam int WL  = 11;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       wake = 1'b0;
  logic [3:0] req = '0;
  logic       cmd_up = 1'b0, cmd_down = 1'b0, fault = 1'b0;
  logic       time_tick = 1'b0;
  logic [7:0] slot_map = 8'b11_10_01_00;
  logic [15:0] dly_cfg = 16'h2222;
  logic [3:0] rail_en;
  logic       busy;
  logic [1:0] mode;

  int compared = 0, mismatched = 0;
  string tag = "R1";
  bit done_flag = 0;

  always #2.5 clk = ~clk;

  rail_strober uut (
    .clk(clk), .rst_n(rst_n), .wake(wake), .req(req), .cmd_up(cmd_up),
    .cmd_down(cmd_down), .fault(fault), .time_tick(time_tick),
    .slot_map(slot_map), .dly_cfg(dly_cfg), .rail_en(rail_en),
    .busy(busy), .mode(mode)
  );

  int tdiv = 0;
  always @(negedge clk) begin
    tdiv = (tdiv + 1) % 4;
    time_tick <= (tdiv == 3);
  end

  // Behavioural reference
  bit m_sleep = 1, m_tosleep = 0, m_lead = 0;
  int m_ph = 0, m_step = 0, m_cnt = 0;
  bit [3:0] m_en = 0, m_reqq = 0;

  function automatic int slot_of(int r);
    return int'(slot_map[2*r +: 2]);
  endfunction

  always @(posedge clk) begin
    bit [3:0] rise, fall, nen;
    int tgt, d;
    bit fire, hold;
    if (!rst_n) begin
      m_sleep = 1; m_ph = 0; m_step = 0; m_cnt = 0; m_en = 0;
      m_tosleep = 0; m_lead = 0; m_reqq = 0;
    end else begin
      rise = req & ~m_reqq;
      fall = ~req & m_reqq;
      nen = m_en;
      hold = 0;
      if (m_ph == 1 && m_step == 0 && m_lead) tgt = WL;
      else begin
        d = (m_ph == 2) ? ((4 - m_step) % 4) : m_step;
        tgt = int'(dly_cfg[d*4 +: 4]) * TPM;
      end
      fire = (m_ph != 0) && (m_cnt == tgt);
      if (m_sleep) begin
        nen = 0;
        if (wake) begin
          m_sleep = 0;
          if (req != 0) begin m_ph = 1; m_step = 0; m_lead = 1; end
        end
      end else if (m_ph == 0) begin
        if (!wake) begin
          if (m_en != 0) begin m_ph = 2; m_step = 0; m_tosleep = 1; end
          else m_sleep = 1;
        end else if (fault || cmd_down) begin
          if (m_en != 0) begin m_ph = 2; m_step = 0; m_tosleep = 0; end
        end else if (cmd_up) begin
          m_ph = 1; m_step = 0; m_lead = 0;
        end else nen = (m_en | rise) & ~fall;
      end else if (m_ph == 1) begin
        if (!wake) begin m_ph = 2; m_step = 0; m_tosleep = 1; end
        else if (fault || cmd_down) begin m_ph = 2; m_step = 0; m_tosleep = 0; end
        else if (fire) begin
          for (int r = 0; r < 4; r++) if (slot_of(r) == m_step) nen[r] = 1;
          if (m_step == 3) m_ph = 0; else m_step++;
        end else hold = 1;
      end else begin
        if (fire) begin
          for (int r = 0; r < 4; r++) if (slot_of(r) == 3 - m_step) nen[r] = 0;
          if (m_step == 3) begin
            m_ph = 0;
            if (m_tosleep || !wake) m_sleep = 1;
          end else m_step++;
        end else hold = 1;
      end
      if (!nen[0]) nen[2] = 0;
      m_en = nen;
      m_cnt = hold ? m_cnt + int'(time_tick) : 0;
      m_reqq = req;
    end
  end

  task automatic chk(string t, int act, int exp);
    compared++;
    if (act != exp) begin
      mismatched++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  // Every-clock comparison against the reference
  always @(negedge clk) if (rst_n && !done_flag) begin
    chk({tag, " rail_en"}, rail_en, m_en);
    chk({tag, " busy"}, busy, m_ph != 0);
    chk({tag, " mode"}, mode, m_sleep ? 0 : (m_en != 0 ? 2 : 1));
  end

  task automatic cyc(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 5000 && busy; i++) @(negedge clk);
  endtask

  task automatic finish_run();
    if (!done_flag) begin
      done_flag = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  endtask

  initial begin
    #1_000_000;
    mismatched++;
    $display("FAIL watchdog: actual hung expected finished");
    finish_run();
  end

  initial begin
    cyc(5); rst_n = 1'b1;
    tag = "R1"; cyc(5);
    chk("R1 reset mode", mode, 0); chk("R1 reset rails", rail_en, 0);

    tag = "R2"; wake = 1'b1; cyc(3);
    chk("R2 standby", mode, 1);

    tag = "R3"; @(negedge clk) cmd_up = 1; @(negedge clk) cmd_up = 0;
    tag = "R8"; cyc(28); req[0] = 1; cyc(3); req[0] = 0; cyc(2);
    req[1] = 1; cyc(2); req[1] = 0;
    wait_idle(); cyc(1);
    chk("R3 all up", rail_en, 4'hF); chk("R8 pins ignored", rail_en, 4'hF);

    tag = "R9"; req[3] = 1; cyc(2); req[3] = 0; cyc(2);
    chk("R9 fall disables", rail_en, 4'b0111);
    tag = "R12"; req[0] = 1; cyc(2); req[0] = 0; cyc(2);
    chk("R12 vneg off drops vpos", rail_en, 4'b0010);
    tag = "R9"; req[1] = 1; cyc(2); req[1] = 0; cyc(2);
    chk("R9 all off standby", mode, 1);
    tag = "R12"; req[2] = 1; cyc(2);
    chk("R12 vpos alone refused", rail_en, 0); req[2] = 0; cyc(2);
    tag = "R9"; req[1] = 1; cyc(2);
    chk("R9 rise enables", rail_en, 4'b0010); chk("R9 active", mode, 2);
    req[1] = 0; cyc(2);

    tag = "R4"; slot_map = 8'b00_10_10_00; dly_cfg = 16'h1031;
    @(negedge clk) cmd_up = 1; @(negedge clk) cmd_up = 0;
    wait_idle(); cyc(1);
    chk("R4 shared and empty slots", rail_en, 4'hF);

    tag = "R6"; @(negedge clk) begin cmd_up = 1; cmd_down = 1; end
    @(negedge clk) begin cmd_up = 0; cmd_down = 0; end
    wait_idle(); cyc(1);
    chk("R6 down wins", rail_en, 0); chk("R5 ends standby", mode, 1);

    tag = "R12"; slot_map = 8'b11_00_10_01; dly_cfg = 16'h2222;
    @(negedge clk) cmd_up = 1; @(negedge clk) cmd_up = 0;
    wait_idle(); cyc(1);
    chk("R12 early vpos dropped", rail_en, 4'b1011);

    tag = "R7"; @(negedge clk) fault = 1; @(negedge clk) fault = 0;
    wait_idle(); cyc(1);
    chk("R7 fault down", rail_en, 0); chk("R7 standby", mode, 1);

    slot_map = 8'b11_10_01_00;
    @(negedge clk) cmd_up = 1; @(negedge clk) cmd_up = 0;
    cyc(40); @(negedge clk) fault = 1; @(negedge clk) fault = 0;
    wait_idle(); cyc(1);
    chk("R7 fault during up", rail_en, 0);

    tag = "R10"; @(negedge clk) cmd_up = 1; @(negedge clk) cmd_up = 0;
    wait_idle(); cyc(1); wake = 0; cyc(2);
    wait_idle(); cyc(2);
    chk("R10 sleep after down", mode, 0); chk("R10 rails off", rail_en, 0);

    tag = "R11"; req = 4'b0001; wake = 1; cyc(2);
    wait_idle(); cyc(1);
    chk("R11 wake with request", rail_en, 4'hF);
    wake = 0; cyc(2); wait_idle(); cyc(2); req = 0; cyc(2);
    chk("R10 sleep again", mode, 0);

    tag = "R10"; wake = 1; cyc(3); chk("R2 standby again", mode, 1);
    wake = 0; cyc(2); chk("R10 sleep no rails", mode, 0);
    cyc(3);
    finish_run();
  end
endmodule